// File: doc/BRIEF.md
# Return Address Stack with Interrupt Gating

This block holds the return addresses of a small microcontroller core in a fixed-depth hardware stack. The core pulses `call_i` on a subroutine call and `ret_i` on either kind of return. An acknowledged interrupt also pushes the address on `pc_i`. After a pop, the saved address appears on `pc_o`. Software has no access to the stored levels or to the level pointer. They change only through these strobes.

The block also decides when an interrupt may be taken. A pulse on `irq_req_i` is held as pending. The acknowledge goes out only when a free level exists and no call or return is active in that cycle. A request that arrives while all levels are occupied therefore waits until a return frees a level. A call, by contrast, is never refused. On a full stack it overwrites the oldest saved address, and the newest `DEPTH` addresses remain.

If a return and a call arrive in the same cycle, only the return takes effect, and the core must present the call again. A return on an empty stack yields zero and raises a one-cycle underflow pulse.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset, `full_o`, `irq_ack_o`, `underflow_o` are 0, `pc_o` is 0 and the stack holds no entries.
- R2: Entries come back last-in first-out. `pc_o` takes the popped value at the clock edge that samples `ret_i` and holds it until the next pop.
- R3: `full_o` is 1 exactly while `DEPTH` (default 8) entries are held. A pop on a full stack clears it at that edge.
- R4: A call on a full stack discards the oldest entry. After `DEPTH+1` calls, `DEPTH` pops return the last `DEPTH` addresses newest first, and the next pop underflows.
- R5: A pop on an empty stack sets `pc_o` to 0 and raises `underflow_o` for that one following cycle. The entry count stays zero.
- R6: A pulse on `irq_req_i` becomes pending at the next edge. `irq_ack_o` is then 1 in a cycle with pending set, the stack not full and neither `call_i` nor `ret_i` high. At that edge the value on `pc_i` is pushed and the pending flag clears.
- R7: While the stack is full, a pending interrupt gets no acknowledge. Once a return frees a level, the acknowledge comes in the first following cycle with no call or return.
- R8: If `ret_i` and `call_i` are both high, only the pop happens and the call is dropped. No acknowledge is given in a cycle with `call_i` or `ret_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| call_i | input | 1 | Subroutine call strobe (push `pc_i`) |
| ret_i | input | 1 | Return strobe for either return kind (pop) |
| irq_req_i | input | 1 | Unmasked interrupt request pulse |
| pc_i | input | PC_W | Address to be saved on a push |
| pc_o | output | PC_W | Most recently restored address |
| irq_ack_o | output | 1 | Interrupt acknowledge grant (combinational) |
| full_o | output | 1 | All levels occupied |
| underflow_o | output | 1 | One-cycle pulse after a pop on an empty stack |

## Verification
`pc_o`, `full_o` and `underflow_o` are registered. Each is due one clock edge after the strobe that causes it, so the bench reads them just after that edge. `irq_ack_o` is combinational from the pending flag and the strobes of the current cycle. The bench therefore reads it shortly after it drives the inputs and before the edge that performs the push. A request pulse appears as an acknowledge no earlier than the following cycle, and the bench's expectations are set to match.

// File: rtl/ret_addr_stack_pkg.sv
package ret_addr_stack_pkg;
  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/ret_addr_stack_ctrl.sv
module ret_addr_stack_ctrl
  import ret_addr_stack_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  stk_op_e                  op,
  output logic [$clog2(DEPTH)-1:0] wr_idx,
  output logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic                     full,
  output logic                     empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign empty  = (cnt_q == '0);
  assign wr_idx = ptr_q;
  assign rd_idx = ptr_q - PTR_W'(1);

  // ring pointer: a push on a full ring overwrites the oldest level
  always_comb begin
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    case (op)
      STK_PUSH: begin
        ptr_d = ptr_q + PTR_W'(1);
        if (!full) cnt_d = cnt_q + CNT_W'(1);
      end
      STK_POP: begin
        if (!empty) begin
          ptr_d = ptr_q - PTR_W'(1);
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ret_addr_stack_store.sv
module ret_addr_stack_store #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 13
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [PC_W-1:0]          wdata,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [PC_W-1:0]          rdata
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0][PC_W-1:0] bank;

  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    logic [PC_W-1:0] lvl_q;
    logic            lvl_en;
    assign lvl_en = we && (wr_idx == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (lvl_en) lvl_q <= wdata;
    end
    assign bank[g] = lvl_q;
  end

  assign rdata = bank[rd_idx];
endmodule

// File: rtl/ret_addr_stack_irq_gate.sv
module ret_addr_stack_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic stk_full,
  input  logic call,
  input  logic ret,
  output logic ack
);
  logic pend_q, pend_d;

  assign ack = pend_q && !stk_full && !call && !ret;

  always_comb begin
    pend_d = pend_q;
    if (ack)     pend_d = 1'b0;
    if (irq_req) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ret_addr_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic            irq_req_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] pc_o,
  output logic            irq_ack_o,
  output logic            full_o,
  output logic            underflow_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic             rst_meta, rst_sync_n;
  stk_op_e          op;
  logic [PTR_W-1:0] wr_idx, rd_idx;
  logic             stk_full, stk_empty;
  logic [PC_W-1:0]  top_val;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic             uf_q, uf_d;
  logic             pop_en, push_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // pop wins over any push in the same cycle
  assign pop_en  = ret_i;
  assign push_en = !ret_i && (call_i || irq_ack_o);

  always_comb begin
    op = STK_IDLE;
    if (pop_en)       op = STK_POP;
    else if (push_en) op = STK_PUSH;
  end

  ret_addr_stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .op     (op),
    .wr_idx (wr_idx),
    .rd_idx (rd_idx),
    .full   (stk_full),
    .empty  (stk_empty)
  );

  ret_addr_stack_store #(.DEPTH(DEPTH), .PC_W(PC_W)) u_store (
    .clk    (clk),
    .we     (push_en),
    .wr_idx (wr_idx),
    .wdata  (pc_i),
    .rd_idx (rd_idx),
    .rdata  (top_val)
  );

  ret_addr_stack_irq_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .irq_req  (irq_req_i),
    .stk_full (stk_full),
    .call     (call_i),
    .ret      (ret_i),
    .ack      (irq_ack_o)
  );

  always_comb begin
    pc_d = pc_q;
    uf_d = 1'b0;
    if (pop_en) begin
      pc_d = stk_empty ? '0 : top_val;
      uf_d = stk_empty;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q <= '0;
      uf_q <= 1'b0;
    end else begin
      pc_q <= pc_d;
      uf_q <= uf_d;
    end
  end

  assign pc_o        = pc_q;
  assign underflow_o = uf_q;
  assign full_o      = stk_full;
endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk #(
  parameter int PC_W = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            call_i,
  input logic            ret_i,
  input logic            irq_req_i,
  input logic [PC_W-1:0] pc_o,
  input logic            irq_ack_o,
  input logic            full_o,
  input logic            underflow_o
);
  // R6/R7: no grant while every level is taken
  a_r7_no_ack_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |-> !full_o);

  // R8: strobes block the grant
  a_r8_no_ack_on_ret: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |-> !irq_ack_o);
  a_r8_no_ack_on_call: assert property (@(posedge clk) disable iff (!rst_n)
    call_i |-> !irq_ack_o);

  // R6: a grant consumes the pending request
  a_r6_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_o && !irq_req_i) |=> !irq_ack_o);

  // R5: underflow only after a pop, with a zero result
  a_r5_uf_after_ret: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> $past(ret_i));
  a_r5_uf_pc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> (pc_o == '0));

  // R3: full persists without a pop, clears with one
  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !ret_i) |=> full_o);
  a_r3_pop_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && ret_i) |=> !full_o);

  // R2: pc_o only moves on a pop
  a_r2_pc_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_i |=> $stable(pc_o));
endmodule

bind ret_addr_stack ret_addr_stack_chk #(.PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .call_i      (call_i),
  .ret_i       (ret_i),
  .irq_req_i   (irq_req_i),
  .pc_o        (pc_o),
  .irq_ack_o   (irq_ack_o),
  .full_o      (full_o),
  .underflow_o (underflow_o)
);

// File: tb/ret_addr_stack_test.sv
module ret_addr_stack_test;
  localparam int  CLK_PERIOD = 10;
  localparam int  DEPTH      = 8;
  localparam int  PC_W       = 13;
  localparam int  NVEC       = 8;
  localparam int  WATCHDOG   = 200000;

  // {call, ret, pc_in[12:0], exp_pc[12:0], exp_full, exp_uf}
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 13'h100, 13'h000, 1'b0, 1'b0},
    {1'b1, 1'b0, 13'h101, 13'h000, 1'b0, 1'b0},
    {1'b1, 1'b0, 13'h102, 13'h000, 1'b0, 1'b0},
    {1'b0, 1'b1, 13'h000, 13'h102, 1'b0, 1'b0},
    {1'b1, 1'b1, 13'h1FF, 13'h101, 1'b0, 1'b0},
    {1'b0, 1'b1, 13'h000, 13'h100, 1'b0, 1'b0},
    {1'b0, 1'b1, 13'h000, 13'h000, 1'b0, 1'b1},
    {1'b0, 1'b0, 13'h000, 13'h000, 1'b0, 1'b0}
  };

  logic            clk;
  logic            rst_n;
  logic            call_i, ret_i, irq_req_i;
  logic [PC_W-1:0] pc_i;
  logic [PC_W-1:0] pc_o;
  logic            irq_ack_o, full_o, underflow_o;
  logic            ack_seen;
  int              n_chk;
  int              n_bad;
  bit              done;

  ret_addr_stack #(.DEPTH(DEPTH), .PC_W(PC_W)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .irq_req_i   (irq_req_i),
    .pc_i        (pc_i),
    .pc_o        (pc_o),
    .irq_ack_o   (irq_ack_o),
    .full_o      (full_o),
    .underflow_o (underflow_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle: inputs at negedge, ack sampled before the edge,
  // registered outputs read just after the edge
  task automatic cyc(input logic c, input logic r, input logic q, input logic [PC_W-1:0] p);
    @(negedge clk);
    call_i = c; ret_i = r; irq_req_i = q; pc_i = p;
    #1 ack_seen = irq_ack_o;
    @(posedge clk);
    #1;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    call_i = 0; ret_i = 0; irq_req_i = 0; pc_i = '0; ack_seen = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1: reset state
    chk("R1 full", full_o, 0);
    chk("R1 ack", irq_ack_o, 0);
    chk("R1 underflow", underflow_o, 0);
    chk("R1 pc", pc_o, 0);

    // R2 / R5 / R8: table walk
    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][29], VEC[i][28], 1'b0, VEC[i][27:15]);
      chk("R2/R5/R8 table pc", pc_o, VEC[i][14:2]);
      chk("R3 table full", full_o, VEC[i][1]);
      chk("R5 table underflow", underflow_o, VEC[i][0]);
    end

    // R3: fill to full
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1'b1, 1'b0, 1'b0, PC_W'(13'h10 + i));
      chk("R3 full during fill", full_o, (i == DEPTH - 1) ? 1 : 0);
    end

    // R7: request while full is held
    cyc(1'b0, 1'b0, 1'b1, '0);
    chk("R7 no ack same cycle", ack_seen, 0);
    cyc(1'b0, 1'b0, 1'b0, '0);
    chk("R7 ack withheld when full", ack_seen, 0);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R8 no ack during ret", ack_seen, 0);
    chk("R2 pop of full stack", pc_o, 13'h17);
    chk("R3 full cleared by pop", full_o, 0);
    cyc(1'b0, 1'b0, 1'b0, 13'h1AA);
    chk("R7 ack after level freed", ack_seen, 1);
    chk("R6 ack pushes to full", full_o, 1);
    cyc(1'b0, 1'b0, 1'b0, '0);
    chk("R6 pending cleared", ack_seen, 0);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R6 pushed ack pc", pc_o, 13'h1AA);

    // R4: overflow drops oldest (now 0x10..0x16 held)
    cyc(1'b1, 1'b0, 1'b0, 13'h20);
    cyc(1'b1, 1'b0, 1'b0, 13'h21);
    chk("R4 full after overflow", full_o, 1);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R4 pop 1", pc_o, 13'h21);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R4 pop 2", pc_o, 13'h20);
    for (int i = 0; i < DEPTH - 2; i++) begin
      cyc(1'b0, 1'b1, 1'b0, '0);
      chk("R4 pop older", pc_o, PC_W'(13'h16 - i));
      chk("R4 no underflow", underflow_o, 0);
    end
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R4 oldest lost, underflow", underflow_o, 1);
    chk("R5 underflow pc zero", pc_o, 0);
    cyc(1'b0, 1'b0, 1'b0, '0);
    chk("R5 underflow one cycle", underflow_o, 0);

    // R5: count stays zero after underflow
    cyc(1'b1, 1'b0, 1'b0, 13'h0AB);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R5 push after underflow", pc_o, 13'h0AB);
    chk("R5 no underflow", underflow_o, 0);

    // R6/R8: call blocks ack, then ack pushes
    cyc(1'b0, 1'b0, 1'b1, '0);
    cyc(1'b1, 1'b0, 1'b0, 13'h055);
    chk("R8 no ack during call", ack_seen, 0);
    cyc(1'b0, 1'b0, 1'b0, 13'h066);
    chk("R6 ack when free", ack_seen, 1);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R6 ack push order", pc_o, 13'h066);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R2 call below ack", pc_o, 13'h055);

    report();
  end
endmodule